// File: doc/BRIEF.md
# Rename Map with Narrow-Value Inlining

This block is the register rename map of an out-of-order core. It is organised as a RAM with one entry per logical register. Each entry holds either a physical register tag or a small constant kept in the entry itself. A per-entry flag says which of the two it holds. At rename, the map supplies the current mappings for two source operands. In the same cycle it can install a fresh physical tag for a destination. Both source reads see the map as it stood before that cycle's write.

When an integer result turns out to fit in a few bits, the writeback stage can store the value directly in the map entry. The map then no longer points at the producing physical register, so the block reports that register as releasable. That release may duplicate a later one, and this is harmless. The inline update is applied only if the entry still names the producing register and the entry has not been renamed in the same cycle. This guard stops a late writeback from overwriting a newer mapping.

A source whose entry is inlined is delivered as an immediate, sign-extended to the full datapath width.

Top module: `rmap_top`

## Requirements
- R1: After reset every entry is unmapped. Any source read returns valid=0, imm=0, tag=0 and data=0.
- R2: A rename write to logical index i with tag t makes later reads of i return valid=1, imm=0 and tag=t, starting with the cycle after the write.
- R3: Source reads are combinational on the current map contents. A read of an index being renamed in the same cycle returns the old mapping.
- R4: A 32-bit result counts as narrow exactly when bits [31:6] all equal bit 6. This means the signed value lies in -64..63, which fits in the 7-bit inline field.
- R5: An inline update is accepted when a narrow writeback names logical index i and producing tag t, and entry i is valid, not inlined, and holds tag t. Reads of i then return imm=1 and data equal to the result, sign-extended from 7 bits, starting with the next cycle.
- R6: A writeback whose result is not narrow leaves the map unchanged and produces no release.
- R7: A writeback whose tag differs from the tag held in the entry leaves the map unchanged and produces no release. This is the case when the entry has since been remapped.
- R8: When a rename write and a writeback target the same index in the same cycle, the rename wins and the writeback is dropped.
- R9: In the cycle after an accepted inline update, relValid is 1 and relTag carries the producing tag. relValid is 0 after every cycle with no accepted update.
- R10: A writeback to an unmapped entry, or to an entry that is already inlined, is dropped with no release.
- R11: A rename write to an inlined entry clears its inline flag, so reads return the new tag with imm=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcAIdx | input | 5 | Logical index of source A |
| srcBIdx | input | 5 | Logical index of source B |
| renWe | input | 1 | Install a new mapping this cycle |
| renIdx | input | 5 | Logical destination index for rename |
| renTag | input | 6 | Physical tag to install |
| wbValid | input | 1 | Writeback result present |
| wbIdx | input | 5 | Logical destination of the writeback |
| wbTag | input | 6 | Physical tag that produced the result |
| wbResult | input | 32 | Result value |
| srcAValid | output | 1 | Source A entry is mapped |
| srcAImm | output | 1 | Source A is an inlined immediate |
| srcATag | output | 6 | Tag field of source A entry |
| srcAData | output | 32 | Sign-extended inline value of A, 0 if not inlined |
| srcBValid | output | 1 | Source B entry is mapped |
| srcBImm | output | 1 | Source B is an inlined immediate |
| srcBTag | output | 6 | Tag field of source B entry |
| srcBData | output | 32 | Sign-extended inline value of B, 0 if not inlined |
| relValid | output | 1 | Release pulse for a physical register |
| relTag | output | 6 | Tag being released |

## Verification
The hardest case to reach is a narrow writeback that meets a rename of the same logical register in the same cycle, with a tag that would otherwise match. It can only arise when the stimulus reuses a tag that is currently in the entry. The bench sets up this collision directly. Its random phase also draws the writeback tag from the model's current mapping half the time and uses a small index range, so that matching tags, remap races and repeated writebacks to inlined entries occur often.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  typedef struct packed {
    logic renWe;
    logic inlineWe;
  } mapStrobe_t;
endpackage

// File: rtl/rmap_narrow_detect.sv
module rmap_narrow_detect #(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 7
) (
  input  logic [DATA_W-1:0] result,
  output logic              isNarrow,
  output logic [VAL_W-1:0]  narrowVal
);
  // narrow when every bit from VAL_W-1 upward copies the sign bit of the field
  assign isNarrow  = (result[DATA_W-1:VAL_W-1] == {(DATA_W-VAL_W+1){result[VAL_W-1]}});
  assign narrowVal = result[VAL_W-1:0];
endmodule

// File: rtl/rmap_ctrl.sv
module rmap_ctrl
  import rmap_pkg::*;
#(
  parameter int LOG_W = 5,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             renWe,
  input  logic [LOG_W-1:0] renIdx,
  input  logic             wbValid,
  input  logic [LOG_W-1:0] wbIdx,
  input  logic [TAG_W-1:0] wbTag,
  input  logic             isNarrow,
  input  logic             wbEntValid,
  input  logic             wbEntInl,
  input  logic [TAG_W-1:0] wbEntTag,
  output mapStrobe_t       strobe,
  output logic             relValid,
  output logic [TAG_W-1:0] relTag
);
  logic tagHit;
  logic renClash;
  logic accept;
  logic relValidQ;
  logic [TAG_W-1:0] relTagQ;

  assign tagHit   = wbEntValid && !wbEntInl && (wbEntTag == wbTag);
  assign renClash = renWe && (renIdx == wbIdx);
  assign accept   = wbValid && isNarrow && tagHit && !renClash;

  always_comb begin
    strobe          = '0;
    strobe.renWe    = renWe;
    strobe.inlineWe = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relValidQ <= 1'b0;
      relTagQ   <= '0;
    end else begin
      relValidQ <= accept;
      if (accept) relTagQ <= wbTag;
    end
  end

  assign relValid = relValidQ;
  assign relTag   = relTagQ;

  // R9: release follows an accepted update, carrying the producing tag
  a_r9_release_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inlineWe |=> (relValid && relTag == $past(wbTag)));
  // R9: no release without an accepted update
  a_r9_no_spurious_release: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.inlineWe |=> !relValid);
endmodule

// File: rtl/rmap_datapath.sv
module rmap_datapath
  import rmap_pkg::*;
#(
  parameter int NUM_LOG = 32,
  parameter int DATA_W  = 32,
  parameter int VAL_W   = 7,
  parameter int LOG_W   = 5,
  parameter int TAG_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strobe,
  input  logic [LOG_W-1:0]  renIdx,
  input  logic [TAG_W-1:0]  renTag,
  input  logic [LOG_W-1:0]  wbIdx,
  input  logic [VAL_W-1:0]  wbVal,
  input  logic [LOG_W-1:0]  srcAIdx,
  input  logic [LOG_W-1:0]  srcBIdx,
  output logic              wbEntValid,
  output logic              wbEntInl,
  output logic [TAG_W-1:0]  wbEntTag,
  output logic              srcAValid,
  output logic              srcAImm,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcBValid,
  output logic              srcBImm,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [DATA_W-1:0] srcBData
);
  localparam int EXT_W = DATA_W - VAL_W;

  logic              validQ [NUM_LOG];
  logic              inlQ   [NUM_LOG];
  logic [TAG_W-1:0]  tagQ   [NUM_LOG];
  logic [VAL_W-1:0]  valQ   [NUM_LOG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LOG; i++) begin
        validQ[i] <= 1'b0;
        inlQ[i]   <= 1'b0;
        tagQ[i]   <= '0;
        valQ[i]   <= '0;
      end
    end else begin
      if (strobe.inlineWe) begin
        inlQ[wbIdx] <= 1'b1;
        valQ[wbIdx] <= wbVal;
      end
      // rename last: it wins any collision
      if (strobe.renWe) begin
        validQ[renIdx] <= 1'b1;
        inlQ[renIdx]   <= 1'b0;
        tagQ[renIdx]   <= renTag;
      end
    end
  end

  assign wbEntValid = validQ[wbIdx];
  assign wbEntInl   = inlQ[wbIdx];
  assign wbEntTag   = tagQ[wbIdx];

  assign srcAValid = validQ[srcAIdx];
  assign srcAImm   = inlQ[srcAIdx];
  assign srcATag   = tagQ[srcAIdx];
  assign srcAData  = inlQ[srcAIdx] ? {{EXT_W{valQ[srcAIdx][VAL_W-1]}}, valQ[srcAIdx]} : '0;

  assign srcBValid = validQ[srcBIdx];
  assign srcBImm   = inlQ[srcBIdx];
  assign srcBTag   = tagQ[srcBIdx];
  assign srcBData  = inlQ[srcBIdx] ? {{EXT_W{valQ[srcBIdx][VAL_W-1]}}, valQ[srcBIdx]} : '0;

  // R2 / R11: rename installs a tag and clears the inline flag
  a_r2_rename_installs: assert property (@(posedge clk) disable iff (!rstN)
    strobe.renWe |=> (validQ[$past(renIdx)] && tagQ[$past(renIdx)] == $past(renTag)));
  a_r11_rename_clears_inline: assert property (@(posedge clk) disable iff (!rstN)
    strobe.renWe |=> !inlQ[$past(renIdx)]);
  // R5: accepted writeback leaves the value inlined
  a_r5_inline_stored: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inlineWe |=> (inlQ[$past(wbIdx)] && valQ[$past(wbIdx)] == $past(wbVal)));
  // R10: the controller only accepts into a mapped, non-inlined entry
  a_r10_target_mapped: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inlineWe |-> (validQ[wbIdx] && !inlQ[wbIdx]));
endmodule

// File: rtl/rmap_top.sv
module rmap_top
  import rmap_pkg::*;
#(
  parameter int NUM_LOG  = 32,
  parameter int NUM_PHYS = 64,
  parameter int DATA_W   = 32,
  parameter int VAL_W    = 7,
  localparam int LOG_W   = $clog2(NUM_LOG),
  localparam int TAG_W   = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LOG_W-1:0]  srcAIdx,
  input  logic [LOG_W-1:0]  srcBIdx,
  input  logic              renWe,
  input  logic [LOG_W-1:0]  renIdx,
  input  logic [TAG_W-1:0]  renTag,
  input  logic              wbValid,
  input  logic [LOG_W-1:0]  wbIdx,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbResult,
  output logic              srcAValid,
  output logic              srcAImm,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcBValid,
  output logic              srcBImm,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [DATA_W-1:0] srcBData,
  output logic              relValid,
  output logic [TAG_W-1:0]  relTag
);
  mapStrobe_t       strobe;
  logic             isNarrow;
  logic [VAL_W-1:0] narrowVal;
  logic             wbEntValid;
  logic             wbEntInl;
  logic [TAG_W-1:0] wbEntTag;

  rmap_narrow_detect #(.DATA_W(DATA_W), .VAL_W(VAL_W)) u_detect (
    .result(wbResult), .isNarrow(isNarrow), .narrowVal(narrowVal)
  );

  rmap_ctrl #(.LOG_W(LOG_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .renWe(renWe), .renIdx(renIdx),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbTag(wbTag), .isNarrow(isNarrow),
    .wbEntValid(wbEntValid), .wbEntInl(wbEntInl), .wbEntTag(wbEntTag),
    .strobe(strobe), .relValid(relValid), .relTag(relTag)
  );

  rmap_datapath #(.NUM_LOG(NUM_LOG), .DATA_W(DATA_W), .VAL_W(VAL_W),
                  .LOG_W(LOG_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .renIdx(renIdx), .renTag(renTag), .wbIdx(wbIdx), .wbVal(narrowVal),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .wbEntValid(wbEntValid), .wbEntInl(wbEntInl), .wbEntTag(wbEntTag),
    .srcAValid(srcAValid), .srcAImm(srcAImm), .srcATag(srcATag), .srcAData(srcAData),
    .srcBValid(srcBValid), .srcBImm(srcBImm), .srcBTag(srcBTag), .srcBData(srcBData)
  );
endmodule

// File: tb/sim_rmap_top.sv
module sim_rmap_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] srcAIdx = '0, srcBIdx = '0, renIdx = '0, wbIdx = '0;
  logic renWe = 1'b0, wbValid = 1'b0;
  logic [5:0] renTag = '0, wbTag = '0;
  logic [31:0] wbResult = '0;
  logic srcAValid, srcAImm, srcBValid, srcBImm, relValid;
  logic [5:0] srcATag, srcBTag, relTag;
  logic [31:0] srcAData, srcBData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  bit mV[32];
  bit mI[32];
  int mT[32];
  int mVal[32];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmap_top u0 (.*);

  task automatic chk(string lab, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", lab, what, act, exp);
    end
  endtask

  task automatic checkReads(string lab);
    chk(lab, "A.valid", srcAValid, mV[srcAIdx]);
    chk(lab, "A.imm",   srcAImm,   mI[srcAIdx]);
    chk(lab, "A.tag",   srcATag,   mT[srcAIdx]);
    chk(lab, "A.data",  $signed(srcAData), mI[srcAIdx] ? mVal[srcAIdx] : 0);
    chk(lab, "B.valid", srcBValid, mV[srcBIdx]);
    chk(lab, "B.imm",   srcBImm,   mI[srcBIdx]);
    chk(lab, "B.tag",   srcBTag,   mT[srcBIdx]);
    chk(lab, "B.data",  $signed(srcBData), mI[srcBIdx] ? mVal[srcBIdx] : 0);
  endtask

  // one clock: inputs already driven; checks reads, advances model, checks release
  task automatic step(string lab);
    int r;
    bit narrow, acc;
    int wi, ri, rt, wt;
    #1;
    checkReads(lab);
    r = $signed(wbResult);
    narrow = (r >= -64) && (r <= 63);   // R4
    wi = wbIdx; ri = renIdx; rt = renTag; wt = wbTag;
    acc = wbValid && narrow && mV[wi] && !mI[wi] && (mT[wi] == wt)
          && !(renWe && ri == wi);
    @(posedge clk);
    #1;
    if (acc) begin mI[wi] = 1; mVal[wi] = r; end
    if (renWe) begin mV[ri] = 1; mI[ri] = 0; mT[ri] = rt; end
    chk("R9", "relValid", relValid, acc);
    if (acc) chk("R9", "relTag", relTag, wt);
    @(negedge clk);
  endtask

  task automatic idle();
    renWe = 0; wbValid = 0;
  endtask

  task automatic ren(int idx, int tag);
    renWe = 1; renIdx = 5'(idx); renTag = 6'(tag);
  endtask

  task automatic wb(int idx, int tag, int res);
    wbValid = 1; wbIdx = 5'(idx); wbTag = 6'(tag); wbResult = 32'(res);
  endtask

  task automatic look(int a, int b);
    srcAIdx = 5'(a); srcBIdx = 5'(b);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mV[i] = 0; mI[i] = 0; mT[i] = 0; mVal[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    look(0, 31); idle(); step("R1");
    look(3, 17); step("R1");
    // R2 / R3: rename r3 -> p10 while reading r3 in the same cycle
    look(3, 3); ren(3, 10); step("R3");
    idle(); step("R2");
    // R5: narrow -5 inlined on matching tag
    wb(3, 10, -5); step("R5");
    idle(); look(3, 0); step("R5");
    // R10: writeback to unmapped entry, and to already-inlined entry
    wb(4, 0, 1); look(4, 3); step("R10");
    idle(); step("R10");
    wb(3, 10, 7); step("R10");
    idle(); step("R10");
    // R6 / R4: boundary values on r5 -> p20
    ren(5, 20); step("R2");
    idle(); wb(5, 20, 64); look(5, 5); step("R6");
    wb(5, 20, -65); step("R6");
    wb(5, 20, 32'h4000_0003); step("R4");
    wb(5, 20, 63); step("R4");
    idle(); step("R5");
    ren(8, 21); step("R2");
    idle(); wb(8, 21, -64); look(8, 5); step("R4");
    idle(); step("R5");
    // R7: remapped entry, stale tag
    ren(6, 21); step("R2");
    ren(6, 22); step("R2");
    idle(); wb(6, 21, 1); look(6, 6); step("R7");
    idle(); step("R7");
    // R8: rename and matching writeback collide
    ren(7, 30); step("R2");
    ren(7, 31); wb(7, 30, 2); look(7, 6); step("R8");
    idle(); step("R8");
    // R11: rename over inlined r3
    ren(3, 11); look(3, 5); step("R11");
    idle(); step("R11");
    // random mix over a small index range
    for (int n = 0; n < 3000; n++) begin
      int wi;
      renWe = ($urandom_range(0, 2) == 0);
      renIdx = 5'($urandom_range(0, 7));
      renTag = 6'($urandom_range(0, 63));
      wbValid = ($urandom_range(0, 1) == 1);
      wi = $urandom_range(0, 7);
      wbIdx = 5'(wi);
      wbTag = ($urandom_range(0, 1) == 1) ? 6'(mT[wi]) : 6'($urandom_range(0, 63));
      case ($urandom_range(0, 3))
        0: wbResult = 32'($urandom_range(0, 127)) - 32'd64;
        1: wbResult = $urandom();
        2: wbResult = 32'($urandom_range(0, 255)) - 32'd128;
        default: wbResult = 32'($urandom_range(0, 63));
      endcase
      srcAIdx = 5'($urandom_range(0, 7));
      srcBIdx = 5'($urandom_range(0, 31));
      step("R5");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule